// File: doc/BRIEF.md
# Queue Error Interrupt and Enable Controller

This block keeps the miscellaneous interrupt state of one instruction queue. Five cause bits record a mailbox write, a doorbell overflow, an instruction fetch read error, a result write error and an engine-reported software error. Each cause has a matching enable bit. The interrupt line is raised while any cause is present together with its enable. The block also holds the queue-enable bit.

Hardware events set cause bits. Software clears causes with a write-one-to-clear access and can force them with a write-one-to-set access. Enables have their own set and clear accesses. Software writes the queue-enable bit directly.

A continue-on-error level chooses between two behaviours. When it is low, any of the three fatal causes (doorbell overflow, read error, result write error) turns the queue off. This applies whether hardware raised the cause or software forced it. When the level is high, those causes are only recorded. Bus decoding and mailbox data storage belong to the surrounding logic. This block receives an already decoded write strobe, a select code and five data bits.

Top module: `qerr_irq_ctrl`

## Requirements
- R1: After reset, the cause vector, the enable vector, the queue enable and the interrupt line are all zero.
- R2: A one-cycle pulse on `hwErr[k]` sets cause bit k+1, and a pulse on `mboxWr` sets cause bit 0. The cause bits are: bit 0 mailbox, bit 1 doorbell overflow, bit 2 instruction read error, bit 3 result write error, bit 4 software error. The new value appears on `causeVec` after the next rising clock edge.
- R3: A write with `wrSel` = 0 clears each cause bit whose `wrData` bit is one and leaves the other cause bits unchanged.
- R4: A write with `wrSel` = 1 sets each cause bit whose `wrData` bit is one.
- R5: If a hardware event and a write-one-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R6: A write with `wrSel` = 2 sets enable bits, and a write with `wrSel` = 3 clears enable bits, at the positions where `wrData` is one. No other access changes `enaVec`, which always shows the current enables.
- R7: `irqOut` is high exactly when some bit is one in both `causeVec` and `enaVec`.
- R8: A write with `wrSel` = 4 loads `wrData[0]` into `queueEna`.
- R9: While `contErr` is low, a hardware event or a write-one-to-set on cause bit 1, 2 or 3 clears `queueEna` on the next edge. This also applies when a queue-enable write of one happens in the same cycle.
- R10: While `contErr` is high, events on cause bits 1, 2 and 3 are recorded but leave `queueEna` unchanged.
- R11: Mailbox and software-error causes never change `queueEna`, whatever the value of `contErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Decoded register write strobe |
| wrSel | input | 3 | Access select: 0 cause clear, 1 cause set, 2 enable set, 3 enable clear, 4 queue enable |
| wrData | input | 5 | Write data, one bit per cause position; bit 0 is the queue-enable value |
| hwErr | input | 4 | Hardware event pulses for cause bits 1 to 4 |
| mboxWr | input | 1 | Pulse when the first mailbox register is written |
| contErr | input | 1 | Continue-on-error level |
| causeVec | output | 5 | Current cause bits |
| enaVec | output | 5 | Current enable bits |
| queueEna | output | 1 | Queue enable |
| irqOut | output | 1 | Interrupt line |

## Verification
Every state change happens on the first rising edge after its stimulus. `causeVec`, `enaVec` and `queueEna` are due after one register stage. `irqOut` is decoded from those registers, so it moves in the same cycle as they do.

The bench drives each stimulus on a falling edge and builds the expected item just after the following rising edge. A monitor compares that item at the next falling edge. Every result is therefore sampled exactly one cycle after its stimulus, half a period away from any edge.

// File: rtl/qerr_pkg.sv
package qerr_pkg;

  localparam int NUM_CAUSE = 5;
  localparam int NUM_HW    = NUM_CAUSE - 1;
  localparam int SEL_W     = 3;

  // cause positions (fixed: software decodes them)
  localparam int MBOX_BIT  = 0;
  localparam int DOVF_BIT  = 1;
  localparam int RDERR_BIT = 2;
  localparam int WRERR_BIT = 3;
  localparam int SWERR_BIT = 4;

  // causes that stop the queue unless continue-on-error is set
  localparam logic [NUM_CAUSE-1:0] KILL_MASK =
    NUM_CAUSE'((1 << DOVF_BIT) | (1 << RDERR_BIT) | (1 << WRERR_BIT));

  typedef enum logic [SEL_W-1:0] {
    SEL_CAUSE_CLR = 3'd0,
    SEL_CAUSE_SET = 3'd1,
    SEL_ENA_SET   = 3'd2,
    SEL_ENA_CLR   = 3'd3,
    SEL_QCTL      = 3'd4
  } wrSel_e;

  typedef struct packed {
    logic [NUM_CAUSE-1:0] causeSet;
    logic [NUM_CAUSE-1:0] causeClr;
    logic [NUM_CAUSE-1:0] enaSet;
    logic [NUM_CAUSE-1:0] enaClr;
    logic                 qWr;
    logic                 qVal;
    logic                 qKill;
  } qerrStrobe_t;

endpackage

// File: rtl/qerr_ctrl.sv
module qerr_ctrl
  import qerr_pkg::*;
(
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic [NUM_CAUSE-1:0] wrData,
  input  logic [NUM_HW-1:0]    hwErr,
  input  logic                 mboxWr,
  input  logic                 contErr,
  output qerrStrobe_t          strobe
);

  logic [NUM_CAUSE-1:0] hwSet;
  logic [NUM_CAUSE-1:0] swSet;
  logic [NUM_CAUSE-1:0] anySet;

  assign hwSet  = {hwErr, mboxWr};
  assign anySet = hwSet | swSet;

  always_comb begin
    swSet           = '0;
    strobe          = '0;
    if (wrEn) begin
      unique case (wrSel)
        SEL_CAUSE_CLR: strobe.causeClr = wrData;
        SEL_CAUSE_SET: swSet           = wrData;
        SEL_ENA_SET:   strobe.enaSet   = wrData;
        SEL_ENA_CLR:   strobe.enaClr   = wrData;
        SEL_QCTL: begin
          strobe.qWr  = 1'b1;
          strobe.qVal = wrData[0];
        end
        default: ;
      endcase
    end
    strobe.causeSet = anySet;
    strobe.qKill    = !contErr && (|(anySet & KILL_MASK));
  end

endmodule

// File: rtl/qerr_dpath.sv
module qerr_dpath
  import qerr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  qerrStrobe_t          strobe,
  output logic [NUM_CAUSE-1:0] causeVec,
  output logic [NUM_CAUSE-1:0] enaVec,
  output logic                 queueEna,
  output logic                 irqOut
);

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)                    causeVec[i] <= 1'b0;
      else if (strobe.causeSet[i])  causeVec[i] <= 1'b1;  // set wins over clear
      else if (strobe.causeClr[i])  causeVec[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                  enaVec[i] <= 1'b0;
      else if (strobe.enaSet[i])  enaVec[i] <= 1'b1;
      else if (strobe.enaClr[i])  enaVec[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             queueEna <= 1'b0;
    else if (strobe.qKill) queueEna <= 1'b0;   // fatal cause beats a write
    else if (strobe.qWr)   queueEna <= strobe.qVal;
  end

  assign irqOut = |(causeVec & enaVec);

endmodule

// File: rtl/qerr_irq_ctrl.sv
module qerr_irq_ctrl
  import qerr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic [NUM_CAUSE-1:0] wrData,
  input  logic [NUM_HW-1:0]    hwErr,
  input  logic                 mboxWr,
  input  logic                 contErr,
  output logic [NUM_CAUSE-1:0] causeVec,
  output logic [NUM_CAUSE-1:0] enaVec,
  output logic                 queueEna,
  output logic                 irqOut
);

  qerrStrobe_t strobe;

  qerr_ctrl ctrl_i (
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .hwErr   (hwErr),
    .mboxWr  (mboxWr),
    .contErr (contErr),
    .strobe  (strobe)
  );

  qerr_dpath dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .causeVec (causeVec),
    .enaVec   (enaVec),
    .queueEna (queueEna),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/qerr_irq_chk.sv
module qerr_irq_chk
  import qerr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [SEL_W-1:0]     wrSel,
  input logic [NUM_CAUSE-1:0] wrData,
  input logic [NUM_HW-1:0]    hwErr,
  input logic                 mboxWr,
  input logic                 contErr,
  input logic [NUM_CAUSE-1:0] causeVec,
  input logic [NUM_CAUSE-1:0] enaVec,
  input logic                 queueEna,
  input logic                 irqOut
);

  // R2 and R5: every hardware event is visible one edge later
  a_r2_hw_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|{hwErr, mboxWr}) |=>
      ((causeVec & $past({hwErr, mboxWr})) == $past({hwErr, mboxWr})));

  // R3: a pure write-one-to-clear removes the addressed bits
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_CAUSE_CLR && hwErr == '0 && !mboxWr) |=>
      ((causeVec & $past(wrData)) == '0));

  // R6: enables move only on enable accesses
  a_r6_ena_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrSel == SEL_ENA_SET || wrSel == SEL_ENA_CLR)) |=> $stable(enaVec));

  // R7: no interrupt without an enable
  a_r7_no_ena_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (enaVec == '0) |-> !irqOut);

  // R9: fatal hardware cause turns the queue off
  a_r9_kill: assert property (@(posedge clk) disable iff (!rstN)
    (!contErr && (|({hwErr, mboxWr} & KILL_MASK))) |=> !queueEna);

  // R10 and R11: with continue-on-error only a queue write moves the enable
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (contErr && !(wrEn && wrSel == SEL_QCTL)) |=> $stable(queueEna));

endmodule

bind qerr_irq_ctrl qerr_irq_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .hwErr    (hwErr),
  .mboxWr   (mboxWr),
  .contErr  (contErr),
  .causeVec (causeVec),
  .enaVec   (enaVec),
  .queueEna (queueEna),
  .irqOut   (irqOut)
);

// File: tb/qerr_irq_ctrl_tb_top.sv
module qerr_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [4:0] wrData = 5'd0;
  logic [3:0] hwErr = 4'd0;
  logic       mboxWr = 1'b0;
  logic       contErr = 1'b0;
  logic [4:0] causeVec, enaVec;
  logic       queueEna, irqOut;

  always #4 clk = ~clk;  // 125 MHz

  qerr_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .hwErr(hwErr), .mboxWr(mboxWr), .contErr(contErr),
    .causeVec(causeVec), .enaVec(enaVec), .queueEna(queueEna), .irqOut(irqOut)
  );

  typedef struct {
    logic [4:0] cause;
    logic [4:0] ena;
    logic       q;
    logic       irq;
    string      req;
  } exp_t;

  exp_t sbq[$];
  int   vecCnt = 0;
  int   failCnt = 0;
  logic [4:0] mCause = '0, mEna = '0;
  logic       mQ = 1'b0;

  // driver: apply one cycle of stimulus and push the model's prediction
  task automatic step(input logic we, input logic [2:0] sel, input logic [4:0] d,
                      input logic [3:0] hw, input logic mb, input logic ce,
                      input string req);
    logic [4:0] setV, clrV;
    logic       kill;
    exp_t       e;
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; hwErr = hw; mboxWr = mb; contErr = ce;
    setV = {hw, mb} | ((we && sel == 3'd1) ? d : 5'd0);
    clrV = (we && sel == 3'd0) ? d : 5'd0;
    kill = !ce && ((setV & 5'b01110) != 5'd0);
    mCause = (mCause & ~clrV) | setV;
    if (we && sel == 3'd2) mEna = mEna | d;
    if (we && sel == 3'd3) mEna = mEna & ~d;
    if (kill) mQ = 1'b0;
    else if (we && sel == 3'd4) mQ = d[0];
    @(posedge clk);
    #1;
    e.cause = mCause; e.ena = mEna; e.q = mQ;
    e.irq = ((mCause & mEna) != 5'd0);
    e.req = req;
    sbq.push_back(e);
  endtask

  task automatic idle(input logic ce, input string req);
    step(1'b0, 3'd0, 5'd0, 4'd0, 1'b0, ce, req);
  endtask

  // monitor: compare each prediction one falling edge after its stimulus edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      vecCnt++;
      if (causeVec !== e.cause) begin
        failCnt++;
        $display("FAIL %s cause actual=%b expected=%b", e.req, causeVec, e.cause);
      end
      if (enaVec !== e.ena) begin
        failCnt++;
        $display("FAIL %s enable actual=%b expected=%b", e.req, enaVec, e.ena);
      end
      if (queueEna !== e.q) begin
        failCnt++;
        $display("FAIL %s queueEna actual=%b expected=%b", e.req, queueEna, e.q);
      end
      if (irqOut !== e.irq) begin
        failCnt++;
        $display("FAIL %s irq actual=%b expected=%b", e.req, irqOut, e.irq);
      end
    end
  end

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1'b1, "R1 reset state");
    step(1'b1, 3'd4, 5'b00001, 4'd0, 1'b0, 1'b1, "R8 queue enable on");
    step(1'b0, 3'd0, 5'd0, 4'b1111, 1'b1, 1'b1, "R2 R10 all hw events");
    step(1'b1, 3'd0, 5'b10101, 4'd0, 1'b0, 1'b1, "R3 w1c subset");
    step(1'b1, 3'd0, 5'b01010, 4'b0100, 1'b0, 1'b1, "R5 hw set beats w1c");
    step(1'b1, 3'd2, 5'b00001, 4'd0, 1'b0, 1'b1, "R6 R7 enable set no cause");
    step(1'b0, 3'd0, 5'd0, 4'd0, 1'b1, 1'b1, "R2 R7 mailbox raises irq");
    step(1'b1, 3'd3, 5'b00001, 4'd0, 1'b0, 1'b1, "R6 R7 enable clear drops irq");
    step(1'b1, 3'd2, 5'b01000, 4'd0, 1'b0, 1'b1, "R7 irq on result error");
    step(1'b1, 3'd0, 5'b11111, 4'd0, 1'b0, 1'b1, "R3 R7 clear all");
    step(1'b1, 3'd1, 5'b00010, 4'd0, 1'b0, 1'b0, "R4 R9 w1s doorbell kills");
    step(1'b1, 3'd4, 5'b00001, 4'd0, 1'b0, 1'b0, "R8 queue re-enable");
    step(1'b0, 3'd0, 5'd0, 4'b1000, 1'b0, 1'b0, "R11 sw error keeps queue");
    step(1'b0, 3'd0, 5'd0, 4'd0, 1'b1, 1'b0, "R11 mailbox keeps queue");
    step(1'b1, 3'd4, 5'b00001, 4'b0010, 1'b0, 1'b0, "R9 read error beats enable write");
    step(1'b1, 3'd4, 5'b00001, 4'd0, 1'b0, 1'b0, "R8 queue re-enable");
    step(1'b0, 3'd0, 5'd0, 4'b0100, 1'b0, 1'b0, "R9 result error kills");
    step(1'b1, 3'd4, 5'b00001, 4'd0, 1'b0, 1'b1, "R8 queue re-enable");
    step(1'b1, 3'd1, 5'b01110, 4'd0, 1'b0, 1'b1, "R10 forced fatal ignored");
    step(1'b1, 3'd4, 5'b00000, 4'd0, 1'b0, 1'b1, "R8 queue write zero");
    step(1'b1, 3'd3, 5'b11111, 4'd0, 1'b0, 1'b1, "R6 clear enables");
    idle(1'b1, "R6 idle hold");
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule